// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Unit

This block serves one processor output of an interrupt controller. Source logic outside the block provides, for each source, a 5-bit priority, an 8-bit vector, a sense bit (1 = level, 0 = edge) and an activity bit. The source logic also sends a one-cycle delivery pulse. The unit keeps two bit-sets indexed by source number: a pending set of delivered interrupts and an in-service set of interrupts the processor has taken. From these sets and a 4-bit task priority it drives the processor's request line.

Software reaches the unit through a small strobe interface with four register selects: 0 = task priority, 1 = spurious vector, 2 = acknowledge, 3 = end-of-interrupt. An acknowledge read takes the best pending source. It either moves that source into service and returns its vector, or it returns the spurious vector. An end-of-interrupt write retires the best in-service entry. When the unit wants the source logic to drop a source's activity bit, it asserts that source's bit of `act_clr` for one cycle.

Top module: `iac_unit`

## Requirements
- R1: After reset the task priority reads 0xF, the spurious vector reads 0xFF, both sets are empty and `irq` is low.
- R2: A delivery pulse puts a source in the pending set only if its priority is nonzero and strictly greater than the task priority. Priorities 16 to 31 always pass against a 4-bit task priority.
- R3: A delivery to a source already in the pending set is dropped, so a single acknowledge empties that source from the set.
- R4: The winner of each set is the member with the highest priority. Among equal priorities the lowest source index wins.
- R5: An acknowledge read with an empty pending set returns the spurious vector.
- R6: If the pending winner's activity bit is 0 at acknowledge, or its priority no longer exceeds the task priority, the read returns the spurious vector. In that case the winner is not placed in service and its `act_clr` bit pulses.
- R7: Otherwise the acknowledge returns the winner's vector and adds the winner to the in-service set.
- R8: Every acknowledge with a nonempty pending set removes the winner from the pending set. A successful acknowledge pulses `act_clr` for the winner only if its sense bit is 0. At most one `act_clr` bit is high in any cycle, and only during an acknowledge.
- R9: An end-of-interrupt write removes only the in-service winner.
- R10: `irq` is high exactly when the pending winner's priority exceeds both the task priority and the in-service winner's priority (or the in-service set is empty).
- R11: Read data appears one cycle after `rd_en`. Select 0 returns {0000, task priority}, select 1 returns the spurious vector, and select 3 returns 0.
- R12: A write to select 0 loads `wdata[3:0]` into the task priority. A write to select 1 loads `wdata[7:0]` into the spurious vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_prio | input | NSRC*5 | Per-source priority, source i at [5i+4:5i] |
| src_vec | input | NSRC*8 | Per-source vector, source i at [8i+7:8i] |
| src_sense | input | NSRC | 1 = level-sensitive, 0 = edge |
| src_act | input | NSRC | Per-source activity bit |
| src_fire | input | NSRC | One-cycle delivery pulse per source |
| act_clr | output | NSRC | Request to clear a source's activity bit |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read select |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is an acknowledge whose pending winner has gone stale. This happens when the source's activity bit drops, or when the task priority is raised above the winner, after delivery and before the read. The bench reaches it by delivering a source and then lowering its activity input, or by writing a higher task priority, before it issues the acknowledge. It then proves that the winner did not enter service by delivering a low-priority source and watching `irq` rise. Tie-breaking in both sets is observed through the returned vectors and through `irq` staying low after a single end-of-interrupt.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int PRIO_W = 5;
  localparam int VEC_W  = 8;
  localparam int TP_W   = 4;

  typedef enum logic [1:0] {
    SEL_TP   = 2'd0,
    SEL_SPUR = 2'd1,
    SEL_ACK  = 2'd2,
    SEL_EOI  = 2'd3
  } reg_sel_e;

  function automatic logic beats_tp(input logic [PRIO_W-1:0] p, input logic [TP_W-1:0] tp);
    return p > {1'b0, tp};
  endfunction

  function automatic logic may_enter(input logic [PRIO_W-1:0] p, input logic [TP_W-1:0] tp);
    return (p != '0) && beats_tp(p, tp);
  endfunction
endpackage

// File: rtl/iac_pick.sv
module iac_pick #(
  parameter int NSRC  = 16,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]                  members,
  input  logic [NSRC*iac_pkg::PRIO_W-1:0]  prio_flat,
  output logic                             found,
  output logic [IDX_W-1:0]                 idx,
  output logic [iac_pkg::PRIO_W-1:0]       best
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (members[i] && (!found || prio_flat[i*iac_pkg::PRIO_W +: iac_pkg::PRIO_W] > best)) begin
        found = 1'b1;
        best  = prio_flat[i*iac_pkg::PRIO_W +: iac_pkg::PRIO_W];
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/iac_regs.sv
module iac_regs (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [1:0]                  rd_sel,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_sel,
  input  logic [iac_pkg::VEC_W-1:0]   wdata,
  input  logic [iac_pkg::VEC_W-1:0]   ack_vec,
  output logic [iac_pkg::TP_W-1:0]    tp,
  output logic [iac_pkg::VEC_W-1:0]   spv,
  output logic [iac_pkg::VEC_W-1:0]   rdata
);
  import iac_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tp    <= 4'hF;
      spv   <= 8'hFF;
      rdata <= '0;
    end else begin
      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_TP:   tp  <= wdata[TP_W-1:0];
          SEL_SPUR: spv <= wdata;
          default: ;
        endcase
      end
      if (rd_en) begin
        case (reg_sel_e'(rd_sel))
          SEL_TP:   rdata <= {{(VEC_W-TP_W){1'b0}}, tp};
          SEL_SPUR: rdata <= spv;
          SEL_ACK:  rdata <= ack_vec;
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/iac_unit.sv
module iac_unit #(
  parameter int NSRC = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NSRC*iac_pkg::PRIO_W-1:0]   src_prio,
  input  logic [NSRC*iac_pkg::VEC_W-1:0]    src_vec,
  input  logic [NSRC-1:0]                   src_sense,
  input  logic [NSRC-1:0]                   src_act,
  input  logic [NSRC-1:0]                   src_fire,
  output logic [NSRC-1:0]                   act_clr,
  input  logic                              rd_en,
  input  logic [1:0]                        rd_sel,
  input  logic                              wr_en,
  input  logic [1:0]                        wr_sel,
  input  logic [iac_pkg::VEC_W-1:0]         wdata,
  output logic [iac_pkg::VEC_W-1:0]         rdata,
  output logic                              irq
);
  import iac_pkg::*;
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]   raised_q, svc_q, fire_ok, win_oh, svc_oh;
  logic              r_found, s_found;
  logic [IDX_W-1:0]  r_idx, s_idx;
  logic [PRIO_W-1:0] r_best, s_best, w_prio;
  logic [VEC_W-1:0]  w_vec, ack_vec, spv;
  logic [TP_W-1:0]   tp;
  logic              w_act, w_sense;
  logic              ack_evt, eoi_evt, ack_hit, ack_spur;

  iac_regs u_regs (
    .clk, .rst_n, .rd_en, .rd_sel, .wr_en, .wr_sel, .wdata,
    .ack_vec, .tp, .spv, .rdata
  );

  iac_pick #(.NSRC(NSRC)) u_pick_raised (
    .members(raised_q), .prio_flat(src_prio),
    .found(r_found), .idx(r_idx), .best(r_best)
  );

  iac_pick #(.NSRC(NSRC)) u_pick_svc (
    .members(svc_q), .prio_flat(src_prio),
    .found(s_found), .idx(s_idx), .best(s_best)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_fire
    assign fire_ok[i] = src_fire[i] && !raised_q[i] &&
                        may_enter(src_prio[i*PRIO_W +: PRIO_W], tp);
  end

  assign ack_evt  = rd_en && (reg_sel_e'(rd_sel) == SEL_ACK);
  assign eoi_evt  = wr_en && (reg_sel_e'(wr_sel) == SEL_EOI);
  assign w_prio   = src_prio[r_idx*PRIO_W +: PRIO_W];
  assign w_vec    = src_vec[r_idx*VEC_W +: VEC_W];
  assign w_act    = src_act[r_idx];
  assign w_sense  = src_sense[r_idx];
  assign win_oh   = r_found ? (NSRC'(1) << r_idx) : '0;
  assign svc_oh   = s_found ? (NSRC'(1) << s_idx) : '0;
  assign ack_hit  = ack_evt && r_found && w_act && beats_tp(w_prio, tp);
  assign ack_spur = ack_evt && r_found && !ack_hit;
  assign ack_vec  = ack_hit ? w_vec : spv;
  assign act_clr  = (ack_spur || (ack_hit && !w_sense)) ? win_oh : '0;
  assign irq      = r_found && beats_tp(r_best, tp) && (!s_found || r_best > s_best);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raised_q <= '0;
      svc_q    <= '0;
    end else begin
      raised_q <= (raised_q | fire_ok) & ~(ack_evt ? win_oh : '0);
      svc_q    <= (svc_q | (ack_hit ? win_oh : '0)) & ~(eoi_evt ? svc_oh : '0);
    end
  end
endmodule

// File: rtl/iac_unit_chk.sv
module iac_unit_chk #(
  parameter int NSRC = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack_evt,
  input logic            eoi_evt,
  input logic [NSRC-1:0] raised_q,
  input logic [NSRC-1:0] svc_q,
  input logic [NSRC-1:0] act_clr,
  input logic [7:0]      spv,
  input logic [7:0]      rdata,
  input logic            irq
);
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_clr)); // R8
  AST_CLR_ONLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_clr != '0) |-> ack_evt); // R8
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raised_q != '0)); // R10
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_evt && !ack_evt && svc_q != '0) |=> $countones(svc_q) == $countones($past(svc_q)) - 1); // R9
  AST_EMPTY_ACK_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && raised_q == '0) |=> rdata == $past(spv)); // R5
endmodule

bind iac_unit iac_unit_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_evt(ack_evt), .eoi_evt(eoi_evt),
  .raised_q(raised_q), .svc_q(svc_q), .act_clr(act_clr),
  .spv(spv), .rdata(rdata), .irq(irq)
);

// File: tb/sim_iac_unit.sv
`timescale 1ns/1ps
module sim_iac_unit;
  localparam int N = 8;

  logic           clk = 0, rst_n = 0;
  logic [N*5-1:0] src_prio = '0;
  logic [N*8-1:0] src_vec = '0;
  logic [N-1:0]   src_sense = '0, src_act = '0, src_fire = '0, act_clr;
  logic           rd_en = 0, wr_en = 0, irq;
  logic [1:0]     rd_sel = 0, wr_sel = 0;
  logic [7:0]     wdata = 0, rdata;

  int checks = 0, errors = 0;
  logic rd_seen = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  iac_unit #(.NSRC(N)) u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      check(rdata === e, t, rdata, e);
    end
  end

  task automatic set_src(input int i, input int p, input int v, input bit s, input bit a);
    src_prio[i*5 +: 5] = 5'(p);
    src_vec[i*8 +: 8]  = 8'(v);
    src_sense[i] = s;
    src_act[i]   = a;
  endtask

  task automatic fire(input int i);
    @(negedge clk); src_fire[i] = 1'b1;
    @(negedge clk); src_fire[i] = 1'b0;
  endtask

  task automatic rd(input int sel, input int exp, input int exp_clr, input string tag);
    @(negedge clk);
    rd_en = 1; rd_sel = 2'(sel);
    exp_q.push_back(8'(exp)); tag_q.push_back(tag);
    #1 check(act_clr === N'(exp_clr), {tag, " act_clr"}, act_clr, exp_clr);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wr(input int sel, input int d);
    @(negedge clk); wr_en = 1; wr_sel = 2'(sel); wdata = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic chk_irq(input bit e, input string tag);
    check(irq === e, tag, irq, e);
  endtask

  task automatic finish_run;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    chk_irq(0, "R1 irq after reset");
    rd(0, 8'h0F, 0, "R1 task priority reset");
    rd(1, 8'hFF, 0, "R1 spurious reset");
    rd(2, 8'hFF, 0, "R5 ack empty after reset");
    rd(3, 8'h00, 0, "R11 eoi reads zero");
    // register writes
    wr(0, 8'hF3);
    rd(0, 8'h03, 0, "R12 task priority write 4 bits");
    wr(1, 8'hA5);
    rd(1, 8'hA5, 0, "R12 spurious write");
    // delivery filter
    set_src(2, 2, 8'h22, 0, 1);
    fire(2);
    chk_irq(0, "R2 prio not above tp");
    rd(2, 8'hA5, 0, "R2 low prio not pending");
    wr(0, 0);
    set_src(5, 0, 8'h55, 0, 1);
    fire(5);
    chk_irq(0, "R2 prio zero");
    rd(2, 8'hA5, 0, "R2 prio zero not pending");
    wr(0, 3);
    // tie-break and in-service interplay
    set_src(3, 6, 8'h33, 0, 1);
    set_src(1, 6, 8'h11, 1, 1);
    set_src(4, 4, 8'h44, 0, 1);
    fire(3); fire(1); fire(4);
    chk_irq(1, "R10 pending above tp");
    rd(2, 8'h11, 0, "R4 tie lowest index / R7 / R8 level no clear");
    chk_irq(0, "R10 equal in-service blocks");
    rd(2, 8'h33, 8'h08, "R7 second winner / R8 edge clear");
    chk_irq(0, "R10 in-service higher");
    wr(3, 0);
    chk_irq(0, "R9 one eoi retires only one");
    wr(3, 0);
    chk_irq(1, "R9 second eoi re-raises");
    rd(2, 8'h44, 8'h10, "R7 low prio after eoi");
    wr(3, 0);
    chk_irq(0, "R10 all idle");
    // miss on re-delivery
    set_src(6, 5, 8'h66, 1, 1);
    fire(6); fire(6);
    rd(2, 8'h66, 0, "R3 first ack");
    rd(2, 8'hA5, 0, "R3 second delivery dropped");
    wr(3, 0);
    // stale winner: inactive
    set_src(7, 7, 8'h77, 1, 1);
    fire(7);
    src_act[7] = 0;
    rd(2, 8'hA5, 8'h80, "R6 inactive winner spurious");
    chk_irq(0, "R6 pending emptied");
    // stale winner: task priority raised
    set_src(2, 9, 8'h22, 1, 1);
    fire(2);
    wr(0, 10);
    rd(2, 8'hA5, 8'h04, "R6 tp raised spurious");
    wr(0, 3);
    fire(4);
    chk_irq(1, "R6 stale winner not in service");
    // priority order across indices
    set_src(0, 5, 8'h0A, 1, 1);
    set_src(6, 12, 8'h66, 1, 1);
    fire(0); fire(6);
    rd(2, 8'h66, 0, "R4 highest priority wins");
    chk_irq(0, "R10 service prio 12 blocks");
    rd(2, 8'h0A, 0, "R4 next priority");
    rd(2, 8'h44, 8'h10, "R4 lowest priority");
    wr(3, 0); wr(3, 0); wr(3, 0);
    chk_irq(0, "R9 all retired");
    rd(2, 8'hA5, 0, "R5 empty again");
    // priorities above 15
    wr(0, 15);
    set_src(5, 20, 8'h55, 0, 1);
    fire(5);
    chk_irq(1, "R2 prio 20 above tp 15");
    rd(2, 8'h55, 8'h20, "R2 prio 20 acked");
    wr(3, 0);
    finish_run();
  end
endmodule